// File: doc/BRIEF.md
# Three-Level Carrier-Disposition PWM Modulator

This block drives the twelve switch gates of a three-phase, three-level neutral-point-clamped inverter. Every phase leg has two outer and two inner switches. A single up/down counter produces a triangular carrier that rises from zero to a programmable peak and falls back. From this count the block forms two carriers: an upper one that covers zero to the peak, and a lower one that covers minus the peak to zero. Each phase's signed modulating sample is first saturated to plus or minus the peak. It is then compared against both carriers. The results are registered as the top and second gate of the leg, and the third and fourth gates are their complements.

One mode input selects how the lower carrier moves. In in-phase disposition it rises and falls together with the upper carrier. In opposition disposition it is the negative of the upper carrier. The carrier half-period sets the switching frequency. The rate at which the controller updates the samples sets the fundamental. For each leg the block also reports a two-bit level code (positive, zero, negative, or idle), which is convenient for monitoring. Deassert the enable, or hold reset, and every gate goes low.

Top module: `tri_level_pwm`

## Requirements
- R1: The carrier count starts at 0. It steps by exactly one per clock up to the active peak P, then back down to 0, so the full cycle is 2P clocks. `valley_o` is high in each cycle where the count is 0 and about to rise while enabled.
- R2: `half_period` is copied into P only in a valley cycle, or in any cycle where `en` is low. A value of 0 is taken as 1.
- R3: Gate g1 (bit 4k of `gate_o` for phase k) is high in the cycle after one in which the saturated sample was strictly greater than the carrier count. Otherwise g1 is low.
- R4: With `opposed` low, the lower carrier is the count minus P. Gate g2 (bit 4k+1) is high in the next cycle exactly when the saturated sample was strictly greater than it.
- R5: With `opposed` high, the lower carrier is the negated count. g2 follows the same strict comparison against it.
- R6: While running, g3 (bit 4k+2) is the inverse of g1 and g4 (bit 4k+3) is the inverse of g2.
- R7: The level code at bits [2k+1:2k] of `level_o` reads 01 (positive) when g1 and g2 are on, 00 (zero) when only g2 is on, and 10 (negative) when neither is on.
- R8: Each sample is saturated to [-P, +P] before comparison. A sample above P therefore leaves g1 low in the cycle after the carrier stood at its peak.
- R9: During reset, and in the cycle after any cycle with `en` low, all gates are 0, every level code reads 11 (idle), and the carrier count is 0. Re-enabling restarts the carrier from its valley.
- R10: All phases share one carrier, but each phase's gates depend only on its own sample field `mod_in[DATA_W*k +: DATA_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle |
| opposed | input | 1 | 0: in-phase carriers, 1: opposition carriers |
| half_period | input | CNT_W | Requested carrier peak P (0 read as 1) |
| mod_in | input | PHASES*DATA_W | Signed modulating samples, phase 0 in the low field |
| gate_o | output | PHASES*4 | Per phase {g4,g3,g2,g1} |
| level_o | output | PHASES*2 | Per-phase level code |
| carrier_o | output | CNT_W | Current carrier count |
| valley_o | output | 1 | Carrier valley strobe |

## Verification
Some properties can be checked on every cycle, and assertions cover them:
- the carrier stays within its peak and moves by single steps;
- the peak changes only after a valley;
- an outer gate is never on without its inner gate;
- the top gate drops after a peak;
- the outputs go idle after a disabled cycle.

Other behaviour only the bench's scenarios can show, because it depends on inputs:
- the exact comparison results under each carrier disposition;
- saturation of out-of-range samples;
- a period change taking effect only at the next valley;
- a zero period being read as one;
- a restart after disable.

// File: rtl/tlp_pkg.sv
`timescale 1ns/1ps
package tlp_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b10,
    LVL_IDLE = 2'b11
  } level_e;

  // level reached by a leg from its two upper-side gates
  function automatic level_e leg_level(input logic top_on, input logic inner_on);
    if (top_on)        return LVL_POS;
    else if (inner_on) return LVL_ZERO;
    else               return LVL_NEG;
  endfunction

endpackage

// File: rtl/tlp_carrier.sv
`timescale 1ns/1ps
module tlp_carrier #(
  parameter int CNT_W    = 10,
  parameter int DEF_HALF = 100,
  parameter int CW       = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 opposed,
  input  logic [CNT_W-1:0]     half_period,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [CNT_W-1:0]     peak_o,
  output logic signed [CW-1:0] lower_o,
  output logic                 valley_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, per_q, hp_eff, per_nx, cnt_inc, cnt_dec;
  logic             up_q;
  logic             valley;

  assign hp_eff  = (half_period == '0) ? ONE : half_period;
  assign valley  = en & up_q & (cnt_q == '0);
  assign per_nx  = (!en || valley) ? hp_eff : per_q;
  assign cnt_inc = cnt_q + ONE;
  assign cnt_dec = cnt_q - ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      per_q <= CNT_W'(DEF_HALF);
    end else if (!en) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      per_q <= hp_eff;
    end else begin
      per_q <= per_nx;
      if (up_q) begin
        cnt_q <= cnt_inc;
        if (cnt_inc == per_nx) up_q <= 1'b0;
      end else begin
        cnt_q <= cnt_dec;
        if (cnt_dec == '0) up_q <= 1'b1;
      end
    end
  end

  // signed views of the count and peak, sized for the comparators
  logic signed [CW-1:0] cnt_s, per_s;
  assign cnt_s = signed'(CW'(cnt_q));
  assign per_s = signed'(CW'(per_q));

  generate
    if (CW > CNT_W) begin : g_lower
      assign lower_o = opposed ? -cnt_s : (cnt_s - per_s);
    end
  endgenerate

  assign cnt_o    = cnt_q;
  assign peak_o   = per_q;
  assign valley_o = valley;

  p_peak_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt_q <= per_q);

  p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(rst_n)) |->
      (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE));

  p_valley_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valley |=> cnt_q == ONE);

  p_period_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && !$past(valley)) |-> per_q == $past(per_q));

endmodule

// File: rtl/tlp_phase.sv
`timescale 1ns/1ps
module tlp_phase
  import tlp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 10,
  parameter int CW     = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [CNT_W-1:0]         peak,
  input  logic signed [CW-1:0]     lower,
  output logic [3:0]               gates,
  output logic [1:0]               level
);

  // saturate a sample to the symmetric range set by the carrier peak
  function automatic logic signed [CW-1:0] saturate(
      input logic signed [DATA_W-1:0] s, input logic [CNT_W-1:0] p);
    logic signed [CW-1:0] sx, px;
    sx = CW'(s);
    px = signed'(CW'(p));
    if (sx > px)       return px;
    else if (sx < -px) return -px;
    else               return sx;
  endfunction

  logic signed [CW-1:0] m_sat, upper_s;
  logic above_upper, above_lower;
  logic g1_q, g2_q, run_q;

  assign m_sat       = saturate(sample, peak);
  assign upper_s     = signed'(CW'(cnt));
  assign above_upper = m_sat > upper_s;
  assign above_lower = m_sat > lower;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q  <= 1'b0;
      g2_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      run_q <= en;
      g1_q  <= en & above_upper;
      g2_q  <= en & above_lower;
    end
  end

  assign gates = {run_q & ~g2_q, run_q & ~g1_q, g2_q, g1_q};
  assign level = run_q ? leg_level(g1_q, g2_q) : LVL_IDLE;

  p_outer_needs_inner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gates[0] |-> gates[1]);

  p_peak_blocks_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == peak) |=> !gates[0]);

  p_idle_after_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |-> (gates == 4'b0000 && level == LVL_IDLE));

  p_no_leg_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates[0] && gates[2]) && !(gates[1] && gates[3]));

endmodule

// File: rtl/tri_level_pwm.sv
`timescale 1ns/1ps
module tri_level_pwm #(
  parameter int PHASES   = 3,
  parameter int DATA_W   = 12,
  parameter int CNT_W    = 10,
  parameter int DEF_HALF = 100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       opposed,
  input  logic [CNT_W-1:0]           half_period,
  input  logic [PHASES*DATA_W-1:0]   mod_in,
  output logic [PHASES*4-1:0]        gate_o,
  output logic [PHASES*2-1:0]        level_o,
  output logic [CNT_W-1:0]           carrier_o,
  output logic                       valley_o
);

  localparam int CW = ((DATA_W > CNT_W + 1) ? DATA_W : CNT_W + 1) + 1;

  logic [CNT_W-1:0]     cnt, peak;
  logic signed [CW-1:0] lower;

  tlp_carrier #(.CNT_W(CNT_W), .DEF_HALF(DEF_HALF), .CW(CW)) u_carrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .opposed    (opposed),
    .half_period(half_period),
    .cnt_o      (cnt),
    .peak_o     (peak),
    .lower_o    (lower),
    .valley_o   (valley_o)
  );

  generate
    for (genvar k = 0; k < PHASES; k++) begin : g_leg
      tlp_phase #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CW(CW)) u_leg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .sample(mod_in[k*DATA_W +: DATA_W]),
        .cnt   (cnt),
        .peak  (peak),
        .lower (lower),
        .gates (gate_o[k*4 +: 4]),
        .level (level_o[k*2 +: 2])
      );
    end
  endgenerate

  assign carrier_o = cnt;

endmodule

// File: tb/tri_level_pwm_tb.sv
`timescale 1ns/1ps
module tri_level_pwm_tb;
  localparam int PH = 3, DW = 12, CWD = 10, DEF = 100;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, opposed = 1'b0;
  logic [CWD-1:0] half_period = 10'd8;
  logic signed [DW-1:0] smp [PH];
  wire  [PH*DW-1:0] mod_in = {smp[2], smp[1], smp[0]};
  logic [PH*4-1:0] gate_o;
  logic [PH*2-1:0] level_o;
  logic [CWD-1:0]  carrier_o;
  logic            valley_o;

  int checks = 0, fails = 0;
  int m_cnt = 0, m_per = DEF;
  bit m_up = 1;
  int e_gate [PH];
  int e_lvl  [PH];
  bit e_idle, e_opp;
  int prev_car;

  always #2.5 clk = ~clk;

  tri_level_pwm #(.PHASES(PH), .DATA_W(DW), .CNT_W(CWD), .DEF_HALF(DEF)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .opposed(opposed), .half_period(half_period),
    .mod_in(mod_in), .gate_o(gate_o), .level_o(level_o), .carrier_o(carrier_o),
    .valley_o(valley_o));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // predict next-edge outputs, advance the model, then compare one cycle later
  task automatic tick();
    int hp, m, lo;
    bit a1, a2;
    hp = (half_period == 0) ? 1 : int'(half_period);
    e_idle = !en;
    e_opp  = opposed;
    for (int p = 0; p < PH; p++) begin
      if (!en) begin
        e_gate[p] = 0; e_lvl[p] = 3;
      end else begin
        m = int'(smp[p]);
        if (m > m_per) m = m_per;
        if (m < -m_per) m = -m_per;
        lo = opposed ? -m_cnt : m_cnt - m_per;
        a1 = m > m_cnt;
        a2 = m > lo;
        e_gate[p] = {!a2, !a1, a2, a1};
        e_lvl[p]  = a1 ? 1 : (a2 ? 0 : 2);
      end
    end
    if (!en) begin
      m_cnt = 0; m_up = 1; m_per = hp;
    end else begin
      if (m_up && m_cnt == 0) m_per = hp;
      if (m_up) begin m_cnt++; if (m_cnt == m_per) m_up = 0; end
      else begin m_cnt--; if (m_cnt == 0) m_up = 1; end
    end
    @(negedge clk);
    chk(int'(carrier_o) == m_cnt, e_idle ? "R9 carrier" : "R1 carrier", int'(carrier_o), m_cnt);
    chk(valley_o == (en && m_up && m_cnt == 0), "R1 valley", int'(valley_o),
        int'(en && m_up && m_cnt == 0));
    for (int p = 0; p < PH; p++) begin
      if (e_idle) begin
        chk(gate_o[4*p +: 4] == 4'b0, "R9 gates idle", int'(gate_o[4*p +: 4]), 0);
        chk(level_o[2*p +: 2] == 2'b11, "R9 level idle", int'(level_o[2*p +: 2]), 3);
      end else begin
        chk(gate_o[4*p] == e_gate[p][0], "R3 g1 R10", int'(gate_o[4*p]), e_gate[p][0]);
        chk(gate_o[4*p+1] == e_gate[p][1], e_opp ? "R5 g2" : "R4 g2",
            int'(gate_o[4*p+1]), e_gate[p][1]);
        chk(gate_o[4*p+2 +: 2] == e_gate[p][3:2], "R6 g3 g4",
            int'(gate_o[4*p+2 +: 2]), e_gate[p][3:2]);
        chk(int'(level_o[2*p +: 2]) == e_lvl[p], "R7 level", int'(level_o[2*p +: 2]), e_lvl[p]);
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(gate_o == '0, "R9 reset gates", int'(gate_o), 0);
    chk(level_o == '1, "R9 reset level", int'(level_o), 63);
    chk(carrier_o == '0, "R9 reset carrier", int'(carrier_o), 0);
    rst_n = 1'b1;
    m_cnt = 0; m_up = 1; m_per = DEF;
    tick();
  endtask

  task automatic t_inphase();
    int valleys = 0;
    half_period = 10'd8; opposed = 1'b0;
    smp[0] = 12'sd5; smp[1] = 12'sd0; smp[2] = -12'sd3;
    en = 1'b1;
    tick();
    for (int i = 0; i < 32; i++) begin
      if (valley_o) valleys++;
      tick();
    end
    chk(valleys == 2, "R1 valleys per 32 cycles at P=8", valleys, 2);
  endtask

  task automatic t_opposed();
    opposed = 1'b1;
    smp[0] = 12'sd7; smp[1] = -12'sd6; smp[2] = 12'sd1;
    repeat (40) tick();
  endtask

  task automatic t_clamp();
    en = 1'b0; half_period = 10'd6; opposed = 1'b0;
    smp[0] = 12'sd2047; smp[1] = -12'sd2048; smp[2] = 12'sd6;
    tick();
    en = 1'b1;
    for (int i = 0; i < 30; i++) begin
      prev_car = int'(carrier_o);
      tick();
      if (prev_car == 6) begin
        chk(gate_o[0] == 1'b0, "R8 saturated top gate at peak", int'(gate_o[0]), 0);
        chk(gate_o[8] == 1'b0, "R8 exact-peak sample at peak", int'(gate_o[8]), 0);
      end else begin
        chk(gate_o[0] == 1'b1, "R8 saturated top gate below peak", int'(gate_o[0]), 1);
      end
      chk(gate_o[5] == 1'b0, "R8 negative saturation keeps g2 low", int'(gate_o[5]), 0);
    end
  endtask

  task automatic t_period();
    int mx = 0;
    // move to the rising slope of a P=6 carrier, then request P=4
    while (!(m_up && m_cnt == 2)) tick();
    half_period = 10'd4;
    while (!(m_up && m_cnt == 0)) begin
      tick();
      if (int'(carrier_o) > mx) mx = int'(carrier_o);
    end
    chk(mx == 6, "R2 old peak kept until valley", mx, 6);
    mx = 0;
    repeat (8) begin
      tick();
      if (int'(carrier_o) > mx) mx = int'(carrier_o);
    end
    chk(mx == 4, "R2 new peak after valley", mx, 4);
  endtask

  task automatic t_zero();
    half_period = 10'd0;
    while (!(m_up && m_cnt == 0)) tick();
    smp[0] = 12'sd1; smp[1] = 12'sd0; smp[2] = -12'sd1;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(int'(carrier_o) == ((i % 2 == 0) ? 1 : 0), "R2 zero period acts as one",
          int'(carrier_o), (i % 2 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_enable();
    half_period = 10'd5;
    smp[0] = 12'sd3; smp[1] = -12'sd2; smp[2] = 12'sd0;
    repeat (7) tick();
    en = 1'b0;
    tick();
    chk(carrier_o == '0, "R9 carrier parked", int'(carrier_o), 0);
    chk(gate_o == '0, "R9 gates off when disabled", int'(gate_o), 0);
    half_period = 10'd3;
    repeat (3) tick();
    en = 1'b1;
    tick();
    chk(int'(carrier_o) == 1, "R9 restart from valley", int'(carrier_o), 1);
    repeat (12) tick();
  endtask

  task automatic t_ramp();
    half_period = 10'd10;
    for (int i = 0; i < 80; i++) begin
      opposed  = (i >= 40);
      smp[0] = 12'(i % 25 - 12);
      smp[1] = 12'(11 - i % 23);
      smp[2] = 12'((i * 7) % 21 - 10);
      tick();
    end
  endtask

  initial begin
    smp[0] = '0; smp[1] = '0; smp[2] = '0;
    t_reset();
    t_inphase();
    t_opposed();
    t_clamp();
    t_period();
    t_zero();
    t_enable();
    t_ramp();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule